// File: doc/BRIEF.md
# Relative Bit-Slip and Frame-Slip Counter

This block measures how far a line clock under test drifts against a reference line clock. Both are recovered clocks at the DS-1 rate, far slower than the system clock that samples them. Each input passes through a synchronizer and a rising-edge detector. In every system cycle the two edge events give a step of +1, −1 or nothing. A signed partial-slip accumulator follows that step. When the accumulator would pass 192 slips in either direction, one frame slip is counted and the accumulator returns to zero. A frame slip is 193 bit slips: 192 payload bits plus the framing bit.

Two wander counters run beside the accumulator. One counts slips where the test clock gained, and the other counts slips where it lost, so the net drift is their difference. The partial accumulator is also split into display indices. A coarse bar index moves one step per group of 16 slips. A fine wheel position gives the slips inside the current group. A synchronous restart input clears every count, so a new measurement can begin without resetting the chip.

Top module: `slip_meter`

## Requirements
- R1: After reset, part_slip, frame_count, frame_dir, pos_wander, neg_wander, bar_idx and wheel_pos are all zero.
- R2: A rising test_clk edge with no reference edge in the same system cycle adds +1 to part_slip. A rising ref_clk edge alone adds −1. part_slip is two's-complement signed and stays within −192..+192.
- R3: Rising edges of both clocks that fall in the same system cycle cancel. No counter moves.
- R4: A +1 step taken while part_slip is +192 sets part_slip to 0, adds one to frame_count and sets frame_dir to 0 (positive).
- R5: A −1 step taken while part_slip is −192 sets part_slip to 0, adds one to frame_count and sets frame_dir to 1 (negative). frame_dir records the sign of the latest frame slip even when the count is saturated.
- R6: frame_count saturates at the FRAME_MAX parameter (default 999) and never wraps.
- R7: bar_idx (signed) and wheel_pos (signed) satisfy part_slip = 16·bar_idx + wheel_pos, with wheel_pos in −7..+8. Examples: +8 gives (0,+8), +9 gives (+1,−7), −8 gives (−1,+8), −7 gives (0,−7) and +192 gives (+12,0).
- R8: pos_wander counts every +1 step and neg_wander counts every −1 step, including steps that cause a frame slip. Equal numbers of test and reference edges leave part_slip at its starting value.
- R9: While restart is high at a system clock edge, that edge clears part_slip, frame_count, frame_dir and both wander counters, and it ignores any step in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than either line clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| restart | input | 1 | Synchronous clear of all counts |
| test_clk | input | 1 | Recovered clock of the line under test |
| ref_clk | input | 1 | Recovered clock of the reference line |
| part_slip | output | ACC_W (9) | Signed partial bit-slip accumulator |
| frame_count | output | FRAME_W (10) | Saturating frame-slip count |
| frame_dir | output | 1 | Sign of the latest frame slip, 1 = negative |
| pos_wander | output | WANDER_W (16) | Count of positive bit slips |
| neg_wander | output | WANDER_W (16) | Count of negative bit slips |
| bar_idx | output | BAR_W (6) | Signed coarse index, one step per 16 slips |
| wheel_pos | output | WHL_W (5) | Signed fine position within a group, −7..+8 |

## Verification
The checks assume that each line clock holds every level for at least one full system cycle. They also assume that both clocks are low when reset is released, so that releasing reset does not itself produce an edge. The stimulus drives both clocks at the falling system edge, holds each level for at least one cycle and keeps both low through reset. After each burst it waits for the synchronizer and edge-detector stages to empty before it samples the outputs. The bench builds the block with a small frame limit so that saturation can be reached in a short run.

// File: rtl/slip_pkg.sv
package slip_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/slip_edge_det.sv
module slip_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/slip_accum.sv
module slip_accum
  import slip_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int FRAME_MAX  = 999,
  parameter int ACC_W      = 9,
  parameter int FRAME_W    = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  step_e                    step,
  output logic signed [ACC_W-1:0]  acc,
  output logic [FRAME_W-1:0]       frames,
  output logic                     dir
);
  localparam logic signed [ACC_W-1:0] POS_END = ACC_W'(FRAME_BITS - 1);
  localparam logic signed [ACC_W-1:0] NEG_END = -POS_END;
  localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(1);
  localparam logic [FRAME_W-1:0]      CAP     = FRAME_W'(FRAME_MAX);

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic [FRAME_W-1:0]      frm_q, frm_d;
  logic                    dir_q, dir_d;
  logic                    wrap;

  always_comb begin
    acc_d = acc_q;
    frm_d = frm_q;
    dir_d = dir_q;
    wrap  = 1'b0;
    if (restart) begin
      acc_d = '0;
      frm_d = '0;
      dir_d = 1'b0;
    end else begin
      case (step)
        STEP_UP: begin
          if (acc_q == POS_END) begin
            acc_d = '0;
            wrap  = 1'b1;
            dir_d = 1'b0;
          end else begin
            acc_d = acc_q + ONE;
          end
        end
        STEP_DOWN: begin
          if (acc_q == NEG_END) begin
            acc_d = '0;
            wrap  = 1'b1;
            dir_d = 1'b1;
          end else begin
            acc_d = acc_q - ONE;
          end
        end
        default: ;
      endcase
      if (wrap && (frm_q != CAP)) frm_d = frm_q + FRAME_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      frm_q <= '0;
      dir_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      frm_q <= frm_d;
      dir_q <= dir_d;
    end
  end

  assign acc    = acc_q;
  assign frames = frm_q;
  assign dir    = dir_q;

  // R2
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= POS_END) && (acc_q >= NEG_END));

  // R6
  frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q <= CAP);

  // R6
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ((frm_q == $past(frm_q)) || (frm_q == $past(frm_q) + FRAME_W'(1))));

  // R4
  frame_zero_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && (step == STEP_UP) && (acc_q == POS_END)) |=> (acc_q == '0) && !dir_q);

  // R5
  frame_neg_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && (step == STEP_DOWN) && (acc_q == NEG_END)) |=> (acc_q == '0) && dir_q);

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (acc_q == '0) && (frm_q == '0) && !dir_q);
endmodule

// File: rtl/slip_wander.sv
module slip_wander
  import slip_pkg::*;
#(
  parameter int WANDER_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  step_e               step,
  output logic [WANDER_W-1:0] pos_cnt,
  output logic [WANDER_W-1:0] neg_cnt
);
  logic [WANDER_W-1:0] pos_q, pos_d, neg_q, neg_d;
  logic                pos_en, neg_en;

  always_comb begin
    pos_en = restart | (step == STEP_UP);
    neg_en = restart | (step == STEP_DOWN);
    pos_d  = restart ? '0 : pos_q + WANDER_W'(1);
    neg_d  = restart ? '0 : neg_q + WANDER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      neg_q <= '0;
    end else begin
      if (pos_en) pos_q <= pos_d;
      if (neg_en) neg_q <= neg_d;
    end
  end

  assign pos_cnt = pos_q;
  assign neg_cnt = neg_q;

  // R8
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> !((pos_q != $past(pos_q)) && (neg_q != $past(neg_q))));

  // R9
  wander_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pos_q == '0) && (neg_q == '0));
endmodule

// File: rtl/slip_display.sv
module slip_display #(
  parameter int ACC_W = 9,
  parameter int GROUP = 16,
  parameter int BAR_W = 6,
  parameter int WHL_W = 5
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [BAR_W-1:0] bar,
  output logic signed [WHL_W-1:0] wheel
);
  localparam int GSH = $clog2(GROUP);
  localparam int OFS = GROUP / 2 - 1;
  localparam logic signed [ACC_W:0]   OFS_A = (ACC_W + 1)'(OFS);
  localparam logic signed [WHL_W-1:0] OFS_W = WHL_W'(OFS);

  logic signed [ACC_W:0] biased;

  always_comb begin
    biased = {acc[ACC_W-1], acc} + OFS_A;
    bar    = biased[ACC_W:GSH];
    wheel  = $signed({1'b0, biased[GSH-1:0]}) - OFS_W;
  end
endmodule

// File: rtl/slip_meter.sv
module slip_meter
  import slip_pkg::*;
#(
  parameter int FRAME_BITS  = 193,
  parameter int FRAME_MAX   = 999,
  parameter int GROUP       = 16,
  parameter int WANDER_W    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ACC_W      = $clog2(FRAME_BITS) + 1,
  localparam int FRAME_W    = $clog2(FRAME_MAX + 1),
  localparam int BAR_W      = ACC_W + 1 - $clog2(GROUP),
  localparam int WHL_W      = $clog2(GROUP) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  logic                     test_clk,
  input  logic                     ref_clk,
  output logic signed [ACC_W-1:0]  part_slip,
  output logic [FRAME_W-1:0]       frame_count,
  output logic                     frame_dir,
  output logic [WANDER_W-1:0]      pos_wander,
  output logic [WANDER_W-1:0]      neg_wander,
  output logic signed [BAR_W-1:0]  bar_idx,
  output logic signed [WHL_W-1:0]  wheel_pos
);
  logic       rst_q1, rst_ns;
  logic [1:0] line_in;
  logic [1:0] line_rise;
  step_e      step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_ns <= rst_q1;
    end
  end

  assign line_in = {ref_clk, test_clk};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    slip_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_ns),
      .din  (line_in[g]),
      .rise (line_rise[g])
    );
  end

  always_comb begin
    case (line_rise)
      2'b01:   step = STEP_UP;
      2'b10:   step = STEP_DOWN;
      default: step = STEP_NONE;
    endcase
  end

  slip_accum #(
    .FRAME_BITS(FRAME_BITS), .FRAME_MAX(FRAME_MAX),
    .ACC_W(ACC_W), .FRAME_W(FRAME_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_ns), .restart(restart), .step(step),
    .acc(part_slip), .frames(frame_count), .dir(frame_dir)
  );

  slip_wander #(.WANDER_W(WANDER_W)) u_wander (
    .clk(clk), .rst_n(rst_ns), .restart(restart), .step(step),
    .pos_cnt(pos_wander), .neg_cnt(neg_wander)
  );

  slip_display #(
    .ACC_W(ACC_W), .GROUP(GROUP), .BAR_W(BAR_W), .WHL_W(WHL_W)
  ) u_disp (
    .acc(part_slip), .bar(bar_idx), .wheel(wheel_pos)
  );

  // R7
  decomp_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (int'(bar_idx) * GROUP + int'(wheel_pos)) == int'(part_slip));

  // R7
  wheel_range_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (int'(wheel_pos) >= -(GROUP / 2 - 1)) && (int'(wheel_pos) <= GROUP / 2));

  // R3
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (&line_rise && !restart) |=> $stable(part_slip) && $stable(pos_wander) && $stable(neg_wander));
endmodule

// File: tb/tb_slip_meter.sv
module tb_slip_meter;
  localparam int FMAX    = 3;
  localparam int ACC_W   = 9;
  localparam int FRAME_W = 2;
  localparam int BAR_W   = 6;
  localparam int WHL_W   = 5;
  localparam int WW      = 16;
  localparam int NVEC    = 13;

  logic clk = 1'b0;
  logic rst_n, restart, test_clk, ref_clk;
  logic signed [ACC_W-1:0] part_slip;
  logic [FRAME_W-1:0]      frame_count;
  logic                    frame_dir;
  logic [WW-1:0]           pos_wander, neg_wander;
  logic signed [BAR_W-1:0] bar_idx;
  logic signed [WHL_W-1:0] wheel_pos;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  slip_meter #(.FRAME_MAX(FMAX)) dut (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .test_clk(test_clk), .ref_clk(ref_clk),
    .part_slip(part_slip), .frame_count(frame_count), .frame_dir(frame_dir),
    .pos_wander(pos_wander), .neg_wander(neg_wander),
    .bar_idx(bar_idx), .wheel_pos(wheel_pos)
  );

  // test pulses, ref pulses, joint pulses, acc, frames, dir, pos, neg, bar, wheel
  localparam int VEC [NVEC][10] = '{
    '{  0,   0, 5,   0, 0, 0,   0,   0,  0,  0},
    '{  3,   0, 4,   3, 0, 0,   3,   0,  0,  3},
    '{  8,   0, 0,   8, 0, 0,   8,   0,  0,  8},
    '{  9,   0, 0,   9, 0, 0,   9,   0,  1, -7},
    '{  0,   8, 0,  -8, 0, 0,   0,   8, -1,  8},
    '{  0,   7, 0,  -7, 0, 0,   0,   7,  0, -7},
    '{192,   0, 0, 192, 0, 0, 192,   0, 12,  0},
    '{193,   0, 0,   0, 1, 0, 193,   0,  0,  0},
    '{  0, 193, 0,   0, 1, 1,   0, 193,  0,  0},
    '{200,   0, 0,   7, 1, 0, 200,   0,  0,  7},
    '{ 20,  20, 0,   0, 0, 0,  20,  20,  0,  0},
    '{  0,  50, 0, -50, 0, 0,   0,  50, -3, -2},
    '{  0, 200, 0,  -7, 1, 1,   0, 200,  0, -7}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic t, input logic r);
    @(negedge clk);
    test_clk = t;
    ref_clk  = r;
    @(negedge clk);
    test_clk = 1'b0;
    ref_clk  = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic check_all(input string tag, input int v [10]);
    chk("R2", {tag, " part_slip"}, int'(part_slip), v[3]);
    chk("R4", {tag, " frame_count"}, int'(frame_count), v[4]);
    chk("R5", {tag, " frame_dir"}, int'(frame_dir), v[5]);
    chk("R8", {tag, " pos_wander"}, int'(pos_wander), v[6]);
    chk("R8", {tag, " neg_wander"}, int'(neg_wander), v[7]);
    chk("R7", {tag, " bar_idx"}, int'(bar_idx), v[8]);
    chk("R7", {tag, " wheel_pos"}, int'(wheel_pos), v[9]);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int zero [10];
    rst_n = 1'b0;
    restart = 1'b0;
    test_clk = 1'b0;
    ref_clk = 1'b0;
    foreach (zero[i]) zero[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1: reset state
    check_all("R1 reset", zero);

    // vector table: R2, R3, R4, R5, R7, R8
    for (int k = 0; k < NVEC; k++) begin
      do_restart();
      for (int i = 0; i < VEC[k][0]; i++) pulse(1'b1, 1'b0);
      for (int i = 0; i < VEC[k][1]; i++) pulse(1'b0, 1'b1);
      for (int i = 0; i < VEC[k][2]; i++) pulse(1'b1, 1'b1);
      settle();
      check_all($sformatf("vec%0d", k), VEC[k]);
    end

    // R8: interleaved wander returns to zero with both counters moving
    do_restart();
    for (int i = 0; i < 30; i++) begin
      pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b1);
    end
    settle();
    chk("R8", "interleave part_slip", int'(part_slip), 0);
    chk("R8", "interleave pos", int'(pos_wander), 30);
    chk("R8", "interleave neg", int'(neg_wander), 30);

    // R6: saturation of frame count at FMAX
    do_restart();
    for (int i = 0; i < 193 * 5; i++) pulse(1'b1, 1'b0);
    settle();
    chk("R6", "saturated frames", int'(frame_count), FMAX);
    chk("R6", "saturated part_slip", int'(part_slip), 0);
    chk("R5", "saturated dir pos", int'(frame_dir), 0);
    for (int i = 0; i < 193; i++) pulse(1'b0, 1'b1);
    settle();
    chk("R6", "still saturated", int'(frame_count), FMAX);
    chk("R5", "dir after neg frame", int'(frame_dir), 1);

    // R9: restart clears within one cycle
    for (int i = 0; i < 10; i++) pulse(1'b1, 1'b0);
    settle();
    chk("R9", "pre-restart part_slip", int'(part_slip), 10);
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R9", "restart part_slip", int'(part_slip), 0);
    chk("R9", "restart frames", int'(frame_count), 0);
    chk("R9", "restart dir", int'(frame_dir), 0);
    chk("R9", "restart pos", int'(pos_wander), 0);
    chk("R9", "restart neg", int'(neg_wander), 0);

    // R9: a step arriving while restart is held is ignored
    @(negedge clk);
    restart = 1'b1;
    test_clk = 1'b1;
    @(negedge clk);
    test_clk = 1'b0;
    repeat (4) @(negedge clk);
    restart = 1'b0;
    settle();
    chk("R9", "step during restart", int'(part_slip), 0);
    chk("R9", "step during restart pos", int'(pos_wander), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule